// File: doc/BRIEF.md
# Interrupt context shadow controller

This block keeps the processor's working context safe across interrupt service, for up to two levels of nesting. When an interrupt is accepted, the live working registers are captured into a first shadow bank. On the same clock edge the previous first-bank contents move down into a second bank. A return command later restores state selectively. Each bit of its 3-bit option field picks one restore action: the main context, the speed register, or a timer adjust that adds the accumulator. The block also owns the global interrupt enable flag.

The processor core drives the interrupt-accept strobe and the return strobe, and it presents the current register values every cycle. The restored values appear on the outputs during the return cycle, together with one load strobe per register group. The core writes them into its register file on that clock edge. All inputs are sampled every cycle and every output is valid in the cycle it is asserted. The interface is single-cycle and has no back-pressure: there is no valid/ready handshake, and the core must accept a load strobe in the cycle it is high.

Top module: `ics_top`

## Requirements
- R1: After reset both shadow banks (main context and speed) read zero, the enable flag `gie_o` is 0 and every load strobe is low.
- R2: An accepted interrupt clears `gie_o` on the next cycle. An interrupt is accepted when `take_i`=1, `gie_o`=1 and `ret_i`=0.
- R3: On an accepted interrupt, the first bank captures the live context, speed and `pc_i`, and the second bank takes the old first-bank contents, all on the same clock edge.
- R4: `take_i` has no effect on the banks or on `gie_o` while `gie_o` is 0 or while `ret_i` is 1 in the same cycle.
- R5: A return (`ret_i`=1) sets `gie_o` on the next cycle, and it overrides a software write of the flag made in the same cycle.
- R6: With no accepted interrupt and no return, `gie_we_i`=1 loads `gie_wd_i` into `gie_o` on the next cycle.
- R7: When `ret_opt_i[1]`=1, the return cycle raises `ctx_load_o` with the first-bank context on the context outputs. The first bank then takes the second bank's value, and the second bank is unchanged.
- R8: When `ret_opt_i[2]`=1, the return cycle raises `spd_load_o` with the first speed shadow on `spd_o`. That shadow then takes its second-bank copy.
- R9: When `ret_opt_i[0]`=1, the return cycle raises `tmr_load_o` with `tmr_o` = (`tmr_i` + `acc_i`) mod 2^8, using the live accumulator input.
- R10: Every return raises `pc_load_o` with `pc_o` equal to the `pc_i` captured at the most recent accepted interrupt.
- R11: All load strobes are low outside a return cycle. A return whose option bit is 0 leaves that bit's strobe low and does not touch that bit's bank.
- R12: An accepted interrupt overrides a software write of the flag made in the same cycle, so `gie_o` clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| take_i | input | 1 | Interrupt accept request |
| pc_i | input | 16 | Program counter to save on accept |
| ret_i | input | 1 | Return-from-interrupt strobe |
| ret_opt_i | input | 3 | Return options: bit0 timer adjust, bit1 context, bit2 speed |
| gie_we_i | input | 1 | Software write of the enable flag |
| gie_wd_i | input | 1 | Value for the software write |
| acc_i | input | 8 | Live accumulator |
| stat_i | input | 8 | Live status register |
| mulhi_i | input | 8 | Live multiply high byte |
| asel_i | input | 8 | Live address-select register |
| iptr_i | input | 16 | Live instruction pointer |
| dptr_i | input | 16 | Live data pointer |
| sptr_i | input | 16 | Live stack pointer |
| dreg_i | input | 16 | Live data register |
| spd_i | input | 8 | Live speed register |
| tmr_i | input | 8 | Live timer register |
| acc_o | output | 8 | Restored accumulator |
| stat_o | output | 8 | Restored status |
| mulhi_o | output | 8 | Restored multiply high byte |
| asel_o | output | 8 | Restored address select |
| iptr_o | output | 16 | Restored instruction pointer |
| dptr_o | output | 16 | Restored data pointer |
| sptr_o | output | 16 | Restored stack pointer |
| dreg_o | output | 16 | Restored data register |
| ctx_load_o | output | 1 | Load strobe for the context group |
| spd_o | output | 8 | Restored speed register |
| spd_load_o | output | 1 | Load strobe for speed |
| tmr_o | output | 8 | Adjusted timer value |
| tmr_load_o | output | 1 | Load strobe for timer |
| pc_o | output | 16 | Return program counter |
| pc_load_o | output | 1 | Load strobe for the program counter |
| gie_o | output | 1 | Global interrupt enable |

## Verification
The assertions check on every cycle that accepted interrupts clear the flag and returns set it. They also check the same-edge capture and push-down of the banks, bank stability when nothing is accepted, the pull-up from the second bank on a context restore, and that load strobes stay quiet outside returns. Only the bench scenarios can show the value-level results across a sequence. These include a nested take and return that restores the outer handler's context, the timer sum with wrap-around, the saved program counter, and the priority among a return, an interrupt and a software write arriving together.

// File: rtl/ics_pkg.sv
package ics_pkg;
  localparam int OPT_W   = 3;
  localparam int OPT_TMR = 0;
  localparam int OPT_CTX = 1;
  localparam int OPT_SPD = 2;

  typedef enum logic [1:0] {
    GIE_HOLD = 2'd0,
    GIE_CLR  = 2'd1,
    GIE_SET  = 2'd2,
    GIE_SW   = 2'd3
  } gie_act_e;
endpackage

// File: rtl/ics_shadow_pair.sv
module ics_shadow_pair #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] live_i,
  output logic [W-1:0] b1_o,
  output logic [W-1:0] b2_o
);
  logic [W-1:0] b1_q, b2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b1_q <= '0;
      b2_q <= '0;
    end else if (push_i) begin
      b1_q <= live_i;
      b2_q <= b1_q;
    end else if (pop_i) begin
      b1_q <= b2_q;
    end
  end

  assign b1_o = b1_q;
  assign b2_o = b2_q;
endmodule

// File: rtl/ics_gie_ctrl.sv
module ics_gie_ctrl
  import ics_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic take_i,
  input  logic ret_i,
  input  logic we_i,
  input  logic wd_i,
  output logic gie_o,
  output logic take_ok_o
);
  logic     gie_q;
  gie_act_e act;

  assign take_ok_o = take_i & gie_q & ~ret_i;

  always_comb begin
    if (ret_i)          act = GIE_SET;
    else if (take_ok_o) act = GIE_CLR;
    else if (we_i)      act = GIE_SW;
    else                act = GIE_HOLD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) gie_q <= 1'b0;
    else begin
      unique case (act)
        GIE_SET:  gie_q <= 1'b1;
        GIE_CLR:  gie_q <= 1'b0;
        GIE_SW:   gie_q <= wd_i;
        default:  gie_q <= gie_q;
      endcase
    end
  end

  assign gie_o = gie_q;
endmodule

// File: rtl/ics_top.sv
module ics_top
  import ics_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int WIDE_W = 16,
  parameter int PC_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic              ret_i,
  input  logic [OPT_W-1:0]  ret_opt_i,
  input  logic              gie_we_i,
  input  logic              gie_wd_i,
  input  logic [BYTE_W-1:0] acc_i,
  input  logic [BYTE_W-1:0] stat_i,
  input  logic [BYTE_W-1:0] mulhi_i,
  input  logic [BYTE_W-1:0] asel_i,
  input  logic [WIDE_W-1:0] iptr_i,
  input  logic [WIDE_W-1:0] dptr_i,
  input  logic [WIDE_W-1:0] sptr_i,
  input  logic [WIDE_W-1:0] dreg_i,
  input  logic [BYTE_W-1:0] spd_i,
  input  logic [BYTE_W-1:0] tmr_i,
  output logic [BYTE_W-1:0] acc_o,
  output logic [BYTE_W-1:0] stat_o,
  output logic [BYTE_W-1:0] mulhi_o,
  output logic [BYTE_W-1:0] asel_o,
  output logic [WIDE_W-1:0] iptr_o,
  output logic [WIDE_W-1:0] dptr_o,
  output logic [WIDE_W-1:0] sptr_o,
  output logic [WIDE_W-1:0] dreg_o,
  output logic              ctx_load_o,
  output logic [BYTE_W-1:0] spd_o,
  output logic              spd_load_o,
  output logic [BYTE_W-1:0] tmr_o,
  output logic              tmr_load_o,
  output logic [PC_W-1:0]   pc_o,
  output logic              pc_load_o,
  output logic              gie_o
);
  localparam int CTX_W = 4 * BYTE_W + 4 * WIDE_W;

  logic             take_ok;
  logic [CTX_W-1:0] ctx_live, ctx_b1, ctx_b2;
  logic [BYTE_W-1:0] spd_b1, spd_b2;
  logic [PC_W-1:0]  pc_q;

  ics_gie_ctrl u_gie (
    .clk(clk), .rst_n(rst_n), .take_i(take_i), .ret_i(ret_i),
    .we_i(gie_we_i), .wd_i(gie_wd_i), .gie_o(gie_o), .take_ok_o(take_ok)
  );

  assign ctx_live = {acc_i, stat_i, mulhi_i, asel_i, iptr_i, dptr_i, sptr_i, dreg_i};

  ics_shadow_pair #(.W(CTX_W)) u_ctx (
    .clk(clk), .rst_n(rst_n), .push_i(take_ok),
    .pop_i(ret_i & ret_opt_i[OPT_CTX]), .live_i(ctx_live),
    .b1_o(ctx_b1), .b2_o(ctx_b2)
  );

  ics_shadow_pair #(.W(BYTE_W)) u_spd (
    .clk(clk), .rst_n(rst_n), .push_i(take_ok),
    .pop_i(ret_i & ret_opt_i[OPT_SPD]), .live_i(spd_i),
    .b1_o(spd_b1), .b2_o(spd_b2)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       pc_q <= '0;
    else if (take_ok) pc_q <= pc_i;
  end

  assign {acc_o, stat_o, mulhi_o, asel_o, iptr_o, dptr_o, sptr_o, dreg_o} = ctx_b1;
  assign ctx_load_o = ret_i & ret_opt_i[OPT_CTX];
  assign spd_o      = spd_b1;
  assign spd_load_o = ret_i & ret_opt_i[OPT_SPD];
  assign tmr_o      = tmr_i + acc_i;
  assign tmr_load_o = ret_i & ret_opt_i[OPT_TMR];
  assign pc_o       = pc_q;
  assign pc_load_o  = ret_i;

  logic unused_b2;
  assign unused_b2 = ^spd_b2;
endmodule

// File: rtl/ics_chk.sv
module ics_chk #(
  parameter int CTX_W = 96,
  parameter int SW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             take_i,
  input logic             ret_i,
  input logic [2:0]       ret_opt_i,
  input logic             gie_o,
  input logic [CTX_W-1:0] ctx_live,
  input logic [CTX_W-1:0] ctx_b1,
  input logic [CTX_W-1:0] ctx_b2,
  input logic [SW-1:0]    spd_b1,
  input logic             ctx_load_o,
  input logic             spd_load_o,
  input logic             tmr_load_o,
  input logic             pc_load_o
);
  logic acc_take;
  assign acc_take = take_i && gie_o && !ret_i;

  assert_take_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_take |=> !gie_o);

  assert_ret_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ret_i |=> gie_o);

  assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_take |=> (ctx_b1 == $past(ctx_live)) && (ctx_b2 == $past(ctx_b1)));

  assert_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ret_i && !acc_take) |=> $stable(ctx_b1) && $stable(ctx_b2) && $stable(spd_b1));

  assert_pull_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && ret_opt_i[1]) |=> (ctx_b1 == $past(ctx_b2)) && $stable(ctx_b2));

  assert_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_i |-> !(ctx_load_o || spd_load_o || tmr_load_o || pc_load_o));
endmodule

bind ics_top ics_chk #(.CTX_W(CTX_W), .SW(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .take_i(take_i), .ret_i(ret_i),
  .ret_opt_i(ret_opt_i), .gie_o(gie_o), .ctx_live(ctx_live),
  .ctx_b1(ctx_b1), .ctx_b2(ctx_b2), .spd_b1(spd_b1),
  .ctx_load_o(ctx_load_o), .spd_load_o(spd_load_o),
  .tmr_load_o(tmr_load_o), .pc_load_o(pc_load_o)
);

// File: tb/tb_ics_top.sv
`timescale 1ns/1ps
module tb_ics_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, take_i, ret_i, gie_we_i, gie_wd_i;
  logic [2:0] ret_opt_i;
  logic [15:0] pc_i, iptr_i, dptr_i, sptr_i, dreg_i;
  logic [7:0] acc_i, stat_i, mulhi_i, asel_i, spd_i, tmr_i;
  logic [7:0] acc_o, stat_o, mulhi_o, asel_o, spd_o, tmr_o;
  logic [15:0] iptr_o, dptr_o, sptr_o, dreg_o, pc_o;
  logic ctx_load_o, spd_load_o, tmr_load_o, pc_load_o, gie_o;

  ics_top dut (.*);

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [95:0] ctx_of(input logic [7:0] s);
    return {s, s ^ 8'h01, s ^ 8'h02, s ^ 8'h03, {s, ~s}, {~s, s}, {s, 8'h5A}, {8'hC3, s}};
  endfunction

  logic [95:0] ctx_out;
  assign ctx_out = {acc_o, stat_o, mulhi_o, asel_o, iptr_o, dptr_o, sptr_o, dreg_o};

  // Reference state derived from the requirements.
  logic [95:0] m_b1, m_b2;
  logic [7:0]  m_s1, m_s2;
  logic [15:0] m_pc;
  logic        m_gie;

  task automatic drive(input logic tk, input logic rt, input logic [2:0] op,
                       input logic we, input logic wd, input logic [7:0] s);
    take_i = tk; ret_i = rt; ret_opt_i = op; gie_we_i = we; gie_wd_i = wd;
    pc_i = {s, ~s};
    {acc_i, stat_i, mulhi_i, asel_i, iptr_i, dptr_i, sptr_i, dreg_i} = ctx_of(s);
    spd_i = s ^ 8'h5A; tmr_i = s + 8'h80;
  endtask

  task automatic step(input logic tk, input logic rt, input logic [2:0] op,
                      input logic we, input logic wd, input logic [7:0] s);
    bit acc_tk;
    @(negedge clk);
    drive(tk, rt, op, we, wd, s);
    #1;
    // combinational outputs in the cycle itself
    chk(ctx_load_o == (rt & op[1]), "R7/R11 ctx_load", 96'(ctx_load_o), 96'(rt & op[1]));
    chk(spd_load_o == (rt & op[2]), "R8/R11 spd_load", 96'(spd_load_o), 96'(rt & op[2]));
    chk(tmr_load_o == (rt & op[0]), "R9/R11 tmr_load", 96'(tmr_load_o), 96'(rt & op[0]));
    chk(pc_load_o == rt, "R10/R11 pc_load", 96'(pc_load_o), 96'(rt));
    if (rt && op[1]) chk(ctx_out == m_b1, "R7 context value", ctx_out, m_b1);
    if (rt && op[2]) chk(spd_o == m_s1, "R8 speed value", 96'(spd_o), 96'(m_s1));
    if (rt && op[0]) chk(tmr_o == 8'(tmr_i + acc_i), "R9 timer sum", 96'(tmr_o), 96'(8'(tmr_i + acc_i)));
    if (rt) chk(pc_o == m_pc, "R10 saved pc", 96'(pc_o), 96'(m_pc));
    // update reference
    acc_tk = tk && m_gie && !rt;
    if (acc_tk) begin
      m_b2 = m_b1; m_b1 = ctx_of(s); m_s2 = m_s1; m_s1 = s ^ 8'h5A; m_pc = {s, ~s};
    end else if (rt) begin
      if (op[1]) m_b1 = m_b2;
      if (op[2]) m_s1 = m_s2;
    end
    if (rt) m_gie = 1'b1;
    else if (acc_tk) m_gie = 1'b0;
    else if (we) m_gie = wd;
    @(posedge clk); #1;
    chk(gie_o == m_gie, "R2/R4/R5/R6/R12 gie", 96'(gie_o), 96'(m_gie));
    chk(ctx_out == m_b1, "R3/R4 bank1", ctx_out, m_b1);
    chk(spd_o == m_s1, "R3/R8 speed bank1", 96'(spd_o), 96'(m_s1));
  endtask

  // {take, ret, opt[2:0], we, wd, seed[7:0], exp_gie}
  localparam int NV = 11;
  localparam logic [15:0] VEC [NV] = '{
    {1'b0,1'b0,3'b000,1'b1,1'b1,8'h00,1'b1}, // R6 software enable
    {1'b1,1'b0,3'b000,1'b0,1'b0,8'h11,1'b0}, // R2 R3 accept
    {1'b1,1'b0,3'b000,1'b0,1'b0,8'h22,1'b0}, // R4 ignored while disabled
    {1'b0,1'b0,3'b000,1'b1,1'b1,8'h00,1'b1}, // R6 nesting enabled
    {1'b1,1'b0,3'b000,1'b0,1'b0,8'h33,1'b0}, // R3 nested accept
    {1'b0,1'b1,3'b110,1'b0,1'b0,8'h00,1'b1}, // R7 R8 restore inner
    {1'b1,1'b0,3'b000,1'b1,1'b1,8'h44,1'b0}, // R12 accept beats write
    {1'b0,1'b1,3'b001,1'b1,1'b0,8'hC0,1'b1}, // R9 R5 R11 timer only
    {1'b1,1'b1,3'b010,1'b0,1'b0,8'h55,1'b1}, // R4 R7 return beats take
    {1'b0,1'b0,3'b000,1'b1,1'b0,8'h00,1'b0}, // R6 software clear
    {1'b0,1'b1,3'b010,1'b0,1'b0,8'h66,1'b1}  // R7 R10 outer restore
  };

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(1'b0, 1'b0, 3'b000, 1'b0, 1'b0, 8'h00);
    m_b1 = '0; m_b2 = '0; m_s1 = '0; m_s2 = '0; m_pc = '0; m_gie = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(gie_o == 1'b0, "R1 gie reset", 96'(gie_o), 96'(0));
    chk(ctx_out == '0, "R1 bank reset", ctx_out, '0);
    chk(spd_o == '0, "R1 speed reset", 96'(spd_o), 96'(0));
    chk(!(ctx_load_o | spd_load_o | tmr_load_o | pc_load_o), "R1 strobes reset", 96'(0), 96'(0));
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][15], VEC[i][14], VEC[i][13:11], VEC[i][10], VEC[i][9], VEC[i][8:1]);
      chk(gie_o == VEC[i][0], "R2/R5/R6 table gie", 96'(gie_o), 96'(VEC[i][0]));
    end

    // R9 wrap-around corner: 0xFF + 0x80 adds to 0x7F
    step(1'b0, 1'b1, 3'b001, 1'b0, 1'b0, 8'hFF);
    // R11: return with no options leaves banks alone but still loads pc
    step(1'b0, 1'b1, 3'b000, 1'b0, 1'b0, 8'h12);
    // R3 second push keeps pushed-down copy, then pull up twice (R7 bank2 unchanged)
    step(1'b1, 1'b0, 3'b000, 1'b0, 1'b0, 8'h77);
    step(1'b0, 1'b0, 3'b000, 1'b1, 1'b1, 8'h00);
    step(1'b1, 1'b0, 3'b000, 1'b0, 1'b0, 8'h88);
    step(1'b0, 1'b1, 3'b110, 1'b0, 1'b0, 8'h00);
    step(1'b0, 1'b1, 3'b110, 1'b0, 1'b0, 8'h00);

    // R1 reset mid-run clears banks and flag
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1;
    chk(gie_o == 1'b0, "R1 gie after reset", 96'(gie_o), 96'(0));
    chk(ctx_out == '0, "R1 bank after reset", ctx_out, '0);
    chk(spd_o == '0, "R1 speed after reset", 96'(spd_o), 96'(0));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule